// File: doc/BRIEF.md
# Parallel Video Sync Word Normalizer

This block sits on a 10-bit parallel video input path and is clocked by the parallel word clock. Each clock it registers one input word. It checks the upper eight bits against the two reserved timing-reference patterns, all zeros and all ones. When one of them is present, it rewrites the two least significant bits to match. After this, a source that drives only the upper eight lines (8-bit video) and a full 10-bit source both give the same 10-bit sync words downstream.

A disable input turns the detection off for parallel data that is not video. The word then passes through unchanged and the detect flag stays low. The output word and the flag come from registers, one clock after the input word was sampled.

Top module: `sync_word_normalizer`

## Requirements
- R1: A synchronous reset clears the output word to 0x000 and the detect flag to 0 on the next rising clock edge.
- R2: Each output word and each flag value shows up exactly one rising clock edge after the input word and disable value they depend on were sampled.
- R3: With detection enabled, an input whose bits 9:2 are all zero (0x000 to 0x003) gives the output 0x000.
- R4: With detection enabled, an input whose bits 9:2 are all one (0x3FC to 0x3FF) gives the output 0x3FF.
- R5: With detection enabled, any input whose bits 9:2 are neither all zero nor all one reaches the output unchanged, and the flag is 0.
- R6: While the disable input is 1, every input word reaches the output unchanged, including reserved codes, and the flag is 0.
- R7: When a reserved code is forced, the values on input bits 1:0 have no effect on the output word.
- R8: The detect flag is 1 for exactly the one clock that follows each sampled reserved word. Back-to-back reserved words keep it at 1, and it returns to 0 after the first non-reserved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| syncDisable | input | 1 | 1 turns reserved-code detection off (pass-through) |
| dataIn | input | 10 | Parallel input word; an 8-bit source uses bits 9:2 |
| dataOut | output | 10 | Registered, normalized output word |
| syncFlag | output | 1 | Registered flag: a reserved word was seen in the previous sample |

## Verification
Both results, the output word and the flag, are due one rising edge after the input is applied. The bench drives each new word and disable value on a falling edge. It compares the outputs on the next falling edge, after exactly one capturing edge has passed. A reset driven mid-stream follows the same timing, so its effect is checked on the falling edge after the edge that applied it. The sweep changes the word every clock, which also checks that the flag drops one clock after a reserved word and stays high across reserved words that arrive back to back.

// File: rtl/sync_norm_pkg.sv
package sync_norm_pkg;
  localparam int DATA_W = 10;
  localparam int LOW_W  = 2;

  typedef struct packed {
    logic forceZero;
    logic forceOne;
    logic hit;
  } normStrobe_t;
endpackage

// File: rtl/norm_control.sv
module norm_control
  import sync_norm_pkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int LowW  = LOW_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 syncDisable,
  input  logic [DataW-1:LowW]  dataHigh,
  output normStrobe_t          strobe,
  output logic                 syncFlag
);
  localparam int HighW = DataW - LowW;

  logic allZero;
  logic allOne;

  always_comb begin
    allZero          = (dataHigh == {HighW{1'b0}});
    allOne           = (dataHigh == {HighW{1'b1}});
    strobe.forceZero = !syncDisable && allZero;
    strobe.forceOne  = !syncDisable && allOne;
    strobe.hit       = strobe.forceZero || strobe.forceOne;
  end

  always_ff @(posedge clk) begin
    if (rst) syncFlag <= 1'b0;
    else     syncFlag <= strobe.hit;
  end

  p_flag_low_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    syncDisable |=> !syncFlag);

  p_flag_zero_code_r8: assert property (@(posedge clk) disable iff (rst)
    (!syncDisable && dataHigh == {HighW{1'b0}}) |=> syncFlag);

  p_flag_one_code_r8: assert property (@(posedge clk) disable iff (rst)
    (!syncDisable && dataHigh == {HighW{1'b1}}) |=> syncFlag);

  p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.forceZero, strobe.forceOne}));
endmodule

// File: rtl/norm_datapath.sv
module norm_datapath
  import sync_norm_pkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int LowW  = LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DataW-1:0]  dataIn,
  input  normStrobe_t       strobe,
  output logic [DataW-1:0]  dataOut
);
  logic [DataW-1:0] nextWord;

  assign nextWord[DataW-1:LowW] = dataIn[DataW-1:LowW];

  for (genvar b = 0; b < LowW; b++) begin : g_low
    assign nextWord[b] = strobe.forceOne  ? 1'b1 :
                         strobe.forceZero ? 1'b0 : dataIn[b];
  end

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= nextWord;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dataOut == '0));

  p_zero_word_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.forceZero |=> (dataOut == '0));

  p_one_word_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.forceOne |=> (dataOut == '1));

  p_passthrough_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.hit |=> (dataOut == $past(dataIn)));

  p_high_bits_kept_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dataOut[DataW-1:LowW] == $past(dataIn[DataW-1:LowW])));
endmodule

// File: rtl/sync_word_normalizer.sv
module sync_word_normalizer
  import sync_norm_pkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int LowW  = LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syncDisable,
  input  logic [DataW-1:0]  dataIn,
  output logic [DataW-1:0]  dataOut,
  output logic              syncFlag
);
  normStrobe_t strobe;

  norm_control #(.DataW(DataW), .LowW(LowW)) uControl (
    .clk         (clk),
    .rst         (rst),
    .syncDisable (syncDisable),
    .dataHigh    (dataIn[DataW-1:LowW]),
    .strobe      (strobe),
    .syncFlag    (syncFlag)
  );

  norm_datapath #(.DataW(DataW), .LowW(LowW)) uDatapath (
    .clk     (clk),
    .rst     (rst),
    .dataIn  (dataIn),
    .strobe  (strobe),
    .dataOut (dataOut)
  );

  p_flag_matches_word_r8: assert property (@(posedge clk) disable iff (rst)
    syncFlag |-> (dataOut == '0 || dataOut == '1));
endmodule

// File: tb/tb_sync_word_normalizer.sv
module tb_sync_word_normalizer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       syncDisable = 1'b0;
  logic [9:0] dataIn = '0;
  logic [9:0] dataOut;
  logic       syncFlag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  sync_word_normalizer dut (
    .clk(clk), .rst(rst), .syncDisable(syncDisable),
    .dataIn(dataIn), .dataOut(dataOut), .syncFlag(syncFlag)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [9:0] expWord, input logic expFlag);
    checks++;
    if (dataOut !== expWord || syncFlag !== expFlag) begin
      fails++;
      $display("FAIL %s: word=%03h flag=%0b, expected word=%03h flag=%0b",
               req, dataOut, syncFlag, expWord, expFlag);
    end
  endtask

  function automatic logic [9:0] expWordOf(input logic [9:0] v, input logic dis);
    int hi = int'(v) / 4;
    if (!dis && hi == 0)   return 10'd0;
    if (!dis && hi == 255) return 10'd1023;
    return v;
  endfunction

  function automatic logic expFlagOf(input logic [9:0] v, input logic dis);
    int hi = int'(v) / 4;
    return !dis && (hi == 0 || hi == 255);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    dataIn = 10'h3FF;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", 10'h000, 1'b0);
    rst = 1'b0;

    // R2..R8: one word per clock, every value, detection on then off
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 1024; v++) begin
        syncDisable = d[0];
        dataIn = v[9:0];
        @(negedge clk);
        if (d == 1)                        tag = "R6 disabled passthrough";
        else if (v < 4)                    tag = "R3/R7/R8 zero code";
        else if (v >= 1020)                tag = "R4/R7/R8 one code";
        else                               tag = "R2/R5 ordinary word";
        check(tag, expWordOf(v[9:0], d[0]), expFlagOf(v[9:0], d[0]));
      end
    end

    // R8: flag drops right after a reserved word
    syncDisable = 1'b0;
    dataIn = 10'h3FE;
    @(negedge clk);
    check("R8 flag high", 10'h3FF, 1'b1);
    dataIn = 10'h155;
    @(negedge clk);
    check("R8 flag drops", 10'h155, 1'b0);

    // R1: mid-stream reset over a reserved code
    dataIn = 10'h3FD;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-stream reset", 10'h000, 1'b0);
    rst = 1'b0;
    dataIn = 10'h001;
    @(negedge clk);
    check("R3 after reset", 10'h000, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule